// File: doc/BRIEF.md
# Tone-Pair Steering Qualifier and Output Latch

This block sits behind a dual-tone detector and replaces an analog RC steering network with counters. The detector supplies an early-steering flag, which is high while it recognises a tone pair, and a 4-bit key code. The block checks that the flag stays high for a programmable number of clock ticks before it accepts the tone. It then loads the code into an output latch and, after a fixed settle delay, raises a delayed-steering flag. That flag stays high until the tone has been absent for a second programmable number of ticks. Gaps in the tone that are shorter than this are bridged.

The software or controller reading the receiver watches the delayed-steering flag and reads the code through an output-enable gate. The high-impedance state is modelled as a drive-enable signal with the data forced to zero. An inhibit input blocks the fourth high-group column (keys A to D). A power-down input forces the qualifier back to idle.

Top module: `tone_steer_latch`

## Requirements
- R1: After reset the latch holds 0000, `dly_steer` is low and both guard counters are zero, so a full present guard time is needed for the first registration.
- R2: A tone is registered on the clock edge that samples the `present_ticks`-th consecutive high value of the qualified early flag. At that edge `det_code` is loaded into the latch. A shorter burst leaves the latch and `dly_steer` unchanged.
- R3: `dly_steer` rises exactly `SETTLE_TICKS` clock edges after the edge that loaded the latch (`SETTLE_TICKS` is 2 or more).
- R4: While `dly_steer` is high, it falls on the edge that samples the `absent_ticks`-th consecutive low value of the qualified early flag. A dropout shorter than this changes neither the flag nor the latch.
- R5: After a registration, no further latch update occurs until a valid pause has lowered `dly_steer`. A held key, or a code change while the key is held, gives exactly one update.
- R6: `q_drive` equals `out_en`. `q_data` shows the latched code when `out_en` is 1 and 0000 when it is 0.
- R7: While `inhibit` is 1, the codes 0000, 1101, 1110 and 1111 (keys D, A, B, C) are treated as an absent tone. All other codes are still accepted.
- R8: `pwr_down` is synchronous. One edge after it is sampled high, `dly_steer` is low and the qualifier is idle with its counters cleared. The latch keeps its contents.
- R9: A guard value of 0 behaves as 1, so a single sampled tick is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Forces the qualifier idle |
| inhibit | input | 1 | Blocks fourth-column keys |
| early_det | input | 1 | Early tone-present flag from the detector |
| det_code | input | 4 | Key code from the detector |
| present_ticks | input | CNT_W | Tone-present guard time in ticks |
| absent_ticks | input | CNT_W | Tone-absent guard time in ticks |
| out_en | input | 1 | Output enable |
| q_drive | output | 1 | Data-bus drive enable (0 means high impedance) |
| q_data | output | 4 | Latched code, gated by the enable |
| dly_steer | output | 1 | Delayed-steering flag |

## Verification
Two events can collide. One is the release of a held tone at the end of the absent guard. The other is a code change or a short dropout arriving inside that same hold window. The bench changes `det_code` and drops the early flag for one tick less than the absent guard while the flag is high. It then checks that the latch and flag stay put, and that the release still lands on the exact edge that R4 predicts. A second collision is a power-down request that arrives while a tone is held. The bench judges this by the flag falling one edge later while the latched code survives.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HOLD   = 2'd2
  } steer_state_t;

  // keys of the fourth high-group column: D=0000, A=1101, B=1110, C=1111
  function automatic logic col4_key(input logic [CODE_W-1:0] code);
    return (code == 4'b0000) || (code == 4'b1101) ||
           (code == 4'b1110) || (code == 4'b1111);
  endfunction
endpackage

// File: rtl/tsl_run_counter.sv
module tsl_run_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  // true when the current sample completes the run; a limit of 0 acts as 1
  function automatic logic reached(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] lim);
    logic [CNT_W:0] nxt;
    nxt = {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
    return nxt >= {1'b0, lim};
  endfunction

  assign hit = run && !clr && reached(cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || !run) cnt <= '0;
    else if (hit)        cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) && $stable(limit) |-> cnt < limit); // R2
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R8
endmodule

// File: rtl/tsl_out_latch.sv
module tsl_out_latch #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] din,
  input  logic              out_en,
  output logic [CODE_W-1:0] held,
  output logic              q_drive,
  output logic [CODE_W-1:0] q_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= din;
  end

  assign q_drive = out_en;
  assign q_data  = out_en ? held : '0;

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held)); // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !q_drive |-> q_data == '0); // R6
endmodule

// File: rtl/tone_steer_latch.sv
module tone_steer_latch #(
  parameter int CNT_W        = 16,
  parameter int SETTLE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             inhibit,
  input  logic             early_det,
  input  logic [3:0]       det_code,
  input  logic [CNT_W-1:0] present_ticks,
  input  logic [CNT_W-1:0] absent_ticks,
  input  logic             out_en,
  output logic             q_drive,
  output logic [3:0]       q_data,
  output logic             dly_steer
);
  import tsl_pkg::*;

  localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_TICKS);

  steer_state_t state;
  logic early_gated;
  logic pres_run, pres_clr, load_evt;
  logic settle_run, settle_hit;
  logic abs_run, abs_clr, abs_hit;
  logic [CNT_W-1:0] pres_cnt, settle_cnt, abs_cnt;
  logic [CODE_W-1:0] latched;

  assign early_gated = early_det && !(inhibit && col4_key(det_code));

  assign pres_clr   = pwr_down || (state != ST_IDLE);
  assign pres_run   = early_gated;
  assign settle_run = (state == ST_SETTLE);
  assign abs_clr    = pwr_down || (state != ST_HOLD);
  assign abs_run    = !early_gated;

  tsl_run_counter #(.CNT_W(CNT_W)) u_pres (
    .clk(clk), .rst_n(rst_n), .clr(pres_clr), .run(pres_run),
    .limit(present_ticks), .cnt(pres_cnt), .hit(load_evt));

  tsl_run_counter #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr(pwr_down), .run(settle_run),
    .limit(SETTLE_LIM), .cnt(settle_cnt), .hit(settle_hit));

  tsl_run_counter #(.CNT_W(CNT_W)) u_abs (
    .clk(clk), .rst_n(rst_n), .clr(abs_clr), .run(abs_run),
    .limit(absent_ticks), .cnt(abs_cnt), .hit(abs_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else if (pwr_down) state <= ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE:   if (load_evt)   state <= ST_SETTLE;
        ST_SETTLE: if (settle_hit) state <= ST_HOLD;
        ST_HOLD:   if (abs_hit)    state <= ST_IDLE;
        default:                   state <= ST_IDLE;
      endcase
    end
  end

  assign dly_steer = (state == ST_HOLD);

  tsl_out_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .din(det_code),
    .out_en(out_en), .held(latched), .q_drive(q_drive), .q_data(q_data));

  AST_FLAG_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dly_steer) |-> $stable(latched)); // R3
  AST_NO_LOAD_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dly_steer |-> !load_evt); // R5
  AST_FALL_NEEDS_ABSENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dly_steer) && !$past(pwr_down) |-> !$past(early_gated)); // R4
  AST_PD_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !dly_steer && pres_cnt == '0 && abs_cnt == '0); // R8
  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit && col4_key(det_code) |-> !load_evt); // R7
endmodule

// File: tb/tone_steer_latch_bench.sv
module tone_steer_latch_bench;
  localparam int CW = 16;
  localparam int P  = 5;
  localparam int A  = 4;
  localparam int S  = 4;

  logic clk = 0, rst_n = 0, pwr_down = 0, inhibit = 0, early_det = 0, out_en = 1;
  logic [3:0] det_code = 0;
  logic [CW-1:0] present_ticks = CW'(P), absent_ticks = CW'(A);
  logic q_drive, dly_steer;
  logic [3:0] q_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] exp_q[$];

  tone_steer_latch #(.CNT_W(CW), .SETTLE_TICKS(S)) u_tone_steer_latch (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .inhibit(inhibit),
    .early_det(early_det), .det_code(det_code), .present_ticks(present_ticks),
    .absent_ticks(absent_ticks), .out_en(out_en), .q_drive(q_drive),
    .q_data(q_data), .dly_steer(dly_steer));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: each rising delayed-steering flag must show the next expected code
  always @(posedge dly_steer) begin
    #1;
    if (rst_n && out_en) begin
      if (exp_q.size() == 0) chk("R5 unexpected registration", 1, 0);
      else chk("R3 scoreboard code", int'(q_data), int'(exp_q.pop_front()));
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    step(2); rst_n = 1; step(1);
    chk("R1 reset latch", int'(q_data), 0);
    chk("R1 reset flag", int'(dly_steer), 0);

    // R2: short burst discarded
    det_code = 4'd7; early_det = 1; step(P - 1); early_det = 0; step(S + 2);
    chk("R2 short burst latch", int'(q_data), 0);
    chk("R2 short burst flag", int'(dly_steer), 0);

    // R2/R3: valid tone
    exp_q.push_back(4'd5);
    det_code = 4'd5; early_det = 1; step(P - 1);
    chk("R2 before guard", int'(q_data), 0);
    step(1);
    chk("R2 loaded at guard", int'(q_data), 5);
    chk("R3 flag still low", int'(dly_steer), 0);
    step(S - 1);
    chk("R3 flag before settle", int'(dly_steer), 0);
    step(1);
    chk("R3 flag after settle", int'(dly_steer), 1);

    // R4/R5: short dropout and code change while held
    early_det = 0; step(A - 1); early_det = 1; det_code = 4'd9; step(P + 3);
    chk("R4 dropout flag", int'(dly_steer), 1);
    chk("R5 held no reload", int'(q_data), 5);
    early_det = 0; step(A - 1);
    chk("R4 flag before pause", int'(dly_steer), 1);
    step(1);
    chk("R4 flag after pause", int'(dly_steer), 0);
    chk("R4 latch kept", int'(q_data), 5);

    // R6: output enable
    out_en = 0; #1;
    chk("R6 drive off", int'(q_drive), 0);
    chk("R6 data off", int'(q_data), 0);
    out_en = 1; #1;
    chk("R6 drive on", int'(q_drive), 1);
    step(2);

    // R7: inhibited key ignored, ordinary key accepted
    inhibit = 1; det_code = 4'b1101; early_det = 1; step(P + S + 2);
    chk("R7 inhibited latch", int'(q_data), 5);
    chk("R7 inhibited flag", int'(dly_steer), 0);
    early_det = 0; step(2);
    exp_q.push_back(4'd3);
    det_code = 4'd3; early_det = 1; step(P + S + 1);
    chk("R7 ordinary accepted", int'(q_data), 3);

    // R8: power-down while held
    pwr_down = 1; early_det = 0; step(1);
    chk("R8 flag cleared", int'(dly_steer), 0);
    chk("R8 latch retained", int'(q_data), 3);
    pwr_down = 0; inhibit = 0; step(2);

    // R9: zero guard acts as one tick
    present_ticks = '0;
    exp_q.push_back(4'd12);
    det_code = 4'd12; early_det = 1; step(1);
    chk("R9 zero guard load", int'(q_data), 12);
    step(S + 2); early_det = 0; step(A + 2);
    chk("R9 released", int'(dly_steer), 0);

    chk("R5 all registrations seen", exp_q.size(), 0);
    summary();
  end
endmodule